// File: doc/BRIEF.md
# Four-Level Page Table Walker

The walker turns a 48-bit linear address into a physical address by reading translation entries from memory, one entry per level. A translation starts from a root base register and goes through four tables in a fixed order: top, pointer, directory and page table. Each entry is 8 bytes and its base field points at the next table. A pointer entry can map a 1 GiB page and a directory entry can map a 2 MiB page; either one ends the walk early. Otherwise the walk finishes at the page table with a 4 KiB frame.

A client presents an address and root value with a valid/ready handshake, and a new translation is taken only while the walker is idle. Memory reads leave through a request port that uses valid/ready, and each read returns as a single-cycle response beat. The result is a one-cycle pulse. It carries either the physical address, the page size code and the combined permissions, or a fault with a code for the level that stopped the walk. Non-canonical addresses are rejected without touching memory, and so are root values with reserved bits set.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. While a walk is running, `req_valid` and the address inputs have no effect.
- R2: If `req_vaddr[63:48]` is not sixteen copies of bit 47, or if `root_base[63:52]` is nonzero, the walker faults with level code 0. It issues no memory read, and `done_valid` rises in the cycle after acceptance.
- R3: The address of each entry read is the current table base (bits 51:12 of the root or of the previous entry), followed by a 9-bit index, followed by three zero bits. The index comes from `req_vaddr[47:39]` at the top level, `[38:30]` at the pointer level, `[29:21]` at the directory level and `[20:12]` at the page-table level.
- R4: `mem_req_valid` stays high, with a stable `mem_req_addr`, until `mem_req_ready` is seen. Each level visited costs exactly one read.
- R5: A visited entry with bit 0 (present) clear ends the walk with a fault. The level code is 4 for the top level, 3 for pointer, 2 for directory and 1 for the page table.
- R6: The following entries are faults. A top-level entry with bit 7 set gives code 4. A 1 GiB pointer entry with any of bits 29:13 set gives code 3. A 2 MiB directory entry with any of bits 20:13 set gives code 2.
- R7: A present pointer entry with bit 7 set gives `done_paddr = {entry[51:30], vaddr[29:0]}` and size code 2, after 2 reads.
- R8: A present directory entry with bit 7 set gives `done_paddr = {entry[51:21], vaddr[20:0]}` and size code 1, after 3 reads.
- R9: Otherwise the page-table entry gives `done_paddr = {entry[51:12], vaddr[11:0]}` and size code 0, after 4 reads.
- R10: `done_write` is the AND of bit 1 over all visited entries. `done_user` is the AND of bit 2. `done_nx` is the OR of bit 63. On a fault, `done_write`, `done_user`, `done_nx` and `done_paddr` are all zero.
- R11: `done_valid` is a one-cycle pulse, one cycle after the final response beat. Nothing is reported outside a translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request may be taken |
| req_vaddr | input | 64 | Linear address to translate |
| root_base | input | 64 | Root register: top table base in bits 51:12 |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data beat valid |
| mem_rsp_data | input | 64 | Entry contents |
| done_valid | output | 1 | Result pulse |
| done_fault | output | 1 | Translation failed |
| done_level | output | 3 | Fault level code (0 pre-check, 4..1 table level) |
| done_paddr | output | PA_W | Translated physical address |
| done_size | output | 2 | 0 = 4 KiB, 1 = 2 MiB, 2 = 1 GiB |
| done_write | output | 1 | Combined write permission |
| done_user | output | 1 | Combined user permission |
| done_nx | output | 1 | Combined execute-disable |

## Verification
The bench aims at three kinds of corner case: early termination at each of the two middle levels, offset splicing at the 21- and 30-bit boundaries, and faults at every level code, including the pre-check codes that must issue no read. A walker that ignored bit 7 would read a fourth table and report the wrong frame. A walker that spliced at the wrong boundary would corrupt the upper offset bits. A walker that let a read escape for a non-canonical address would show up in the read count. Tables with mixed write and execute-disable bits catch permission combining done at the leaf only. Back-pressure on the memory request port and a second request held during a busy walk show whether the address is held and whether extra requests leak in.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic [63:0]     root_base,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done_valid,
  output logic            done_fault,
  output logic [2:0]      done_level,
  output logic [PA_W-1:0] done_paddr,
  output logic [1:0]      done_size,
  output logic            done_write,
  output logic            done_user,
  output logic            done_nx
);

  localparam int BW = PA_W - 12;

  typedef enum logic [1:0] {IDLE, ISSUE, WAIT} st_t;

  st_t            state;
  logic [47:0]    va_q;
  logic [BW-1:0]  base_q;
  logic [1:0]     lvl_q;
  logic           wr_q, us_q, xd_q;
  logic [8:0]     idx;
  logic [PA_W-1:0] leaf_pa;

  wire [63:0] e      = mem_rsp_data;
  wire        ps     = e[7];
  wire        n_wr   = wr_q & e[1];
  wire        n_us   = us_q & e[2];
  wire        n_xd   = xd_q | e[63];
  wire        bad_in = (req_vaddr[63:48] != {16{req_vaddr[47]}}) | (|root_base[63:PA_W]);
  wire        rsv    = (lvl_q == 2'd3 && ps) ||
                       (lvl_q == 2'd2 && ps && |e[29:13]) ||
                       (lvl_q == 2'd1 && ps && |e[20:13]);
  wire        leaf   = (lvl_q == 2'd0) || (ps && (lvl_q == 2'd2 || lvl_q == 2'd1));
  wire        unused_bits = ^{root_base[11:0], e[62:PA_W], e[11:8], e[6:3]};

  assign req_ready     = (state == IDLE);
  assign mem_req_valid = (state == ISSUE);
  assign mem_req_addr  = {base_q, idx, 3'b000};

  always_comb begin
    case (lvl_q)
      2'd3:    idx = va_q[47:39];
      2'd2:    idx = va_q[38:30];
      2'd1:    idx = va_q[29:21];
      default: idx = va_q[20:12];
    endcase
  end

  always_comb begin
    case (lvl_q)
      2'd2:    leaf_pa = {e[PA_W-1:30], va_q[29:0]};
      2'd1:    leaf_pa = {e[PA_W-1:21], va_q[20:0]};
      default: leaf_pa = {e[PA_W-1:12], va_q[11:0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      va_q       <= '0;
      base_q     <= '0;
      lvl_q      <= 2'd3;
      wr_q       <= 1'b0;
      us_q       <= 1'b0;
      xd_q       <= 1'b0;
      done_valid <= 1'b0;
      done_fault <= 1'b0;
      done_level <= 3'd0;
      done_paddr <= '0;
      done_size  <= 2'd0;
      done_write <= 1'b0;
      done_user  <= 1'b0;
      done_nx    <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          va_q <= req_vaddr[47:0];
          if (bad_in) begin
            done_valid <= 1'b1;
            done_fault <= 1'b1;
            done_level <= 3'd0;
            done_paddr <= '0;
            done_size  <= 2'd0;
            done_write <= 1'b0;
            done_user  <= 1'b0;
            done_nx    <= 1'b0;
          end else begin
            base_q <= root_base[PA_W-1:12];
            lvl_q  <= 2'd3;
            wr_q   <= 1'b1;
            us_q   <= 1'b1;
            xd_q   <= 1'b0;
            state  <= ISSUE;
          end
        end
        ISSUE: if (mem_req_ready) state <= WAIT;
        WAIT: if (mem_rsp_valid) begin
          wr_q <= n_wr;
          us_q <= n_us;
          xd_q <= n_xd;
          if (!e[0] || rsv) begin
            done_valid <= 1'b1;
            done_fault <= 1'b1;
            done_level <= {1'b0, lvl_q} + 3'd1;
            done_paddr <= '0;
            done_size  <= 2'd0;
            done_write <= 1'b0;
            done_user  <= 1'b0;
            done_nx    <= 1'b0;
            state      <= IDLE;
          end else if (leaf) begin
            done_valid <= 1'b1;
            done_fault <= 1'b0;
            done_level <= 3'd0;
            done_paddr <= leaf_pa;
            done_size  <= lvl_q;
            done_write <= n_wr;
            done_user  <= n_us;
            done_nx    <= n_xd;
            state      <= IDLE;
          end else begin
            base_q <= e[PA_W-1:12];
            lvl_q  <= lvl_q - 2'd1;
            state  <= ISSUE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R4

  AST_PRECHECK_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && bad_in |=> done_valid && done_fault && done_level == 3'd0 && !mem_req_valid); // R2

  AST_WALK_END_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !(done_fault && done_level == 3'd0) |-> $past(mem_rsp_valid)); // R11

  AST_GIANT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_fault && done_size == 2'd2 |-> done_paddr[29:0] == va_q[29:0]); // R7

  AST_LARGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_fault && done_size == 2'd1 |-> done_paddr[20:0] == va_q[20:0]); // R8

  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> !done_write && !done_user && !done_nx); // R10

endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_vaddr = '0;
  logic [63:0] root_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [51:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid, done_fault, done_write, done_user, done_nx;
  logic [2:0]  done_level;
  logic [51:0] done_paddr;
  logic [1:0]  done_size;

  pt_walker #(.PA_W(52)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .root_base(root_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_fault(done_fault), .done_level(done_level),
    .done_paddr(done_paddr), .done_size(done_size),
    .done_write(done_write), .done_user(done_user), .done_nx(done_nx)
  );

  typedef struct packed {
    logic        fault;
    logic [2:0]  lvl;
    logic [51:0] pa;
    logic [1:0]  sz;
    logic        wr, us, xd;
    logic [3:0]  reads;
  } exp_t;

  localparam logic [63:0] P  = 64'h1;
  localparam logic [63:0] W  = 64'h2;
  localparam logic [63:0] U  = 64'h4;
  localparam logic [63:0] PS = 64'h80;
  localparam logic [63:0] XD = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PWU = 64'h7;

  int checks = 0;
  int errors = 0;
  exp_t  expq[$];
  string tagq[$];

  logic [63:0] mem [logic [51:0]];
  logic [63:0] next_tbl = 64'h10000;
  int unsigned req_cnt = 0;
  int unsigned rsp_cnt = 0;
  int unsigned rd_base = 0;
  logic [51:0] rd_addr = '0;
  logic        stall = 1'b0;
  int unsigned cyc = 0;
  logic        hold_prev = 1'b0;
  logic [51:0] prev_addr = '0;
  int r4_viol = 0;
  int r1_viol = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (hold_prev && !(mem_req_valid && mem_req_addr == prev_addr)) r4_viol <= r4_viol + 1;
    hold_prev <= mem_req_valid && !mem_req_ready;
    prev_addr <= mem_req_addr;
    if (mem_req_valid && mem_req_ready) begin
      req_cnt <= req_cnt + 1;
      rd_addr <= mem_req_addr;
    end
  end

  always @(negedge clk) begin
    mem_req_ready = stall ? (cyc[1:0] != 2'd0) : 1'b1;
    if (req_cnt != rsp_cnt) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem.exists(rd_addr) ? mem[rd_addr] : 64'h0;
      rsp_cnt = rsp_cnt + 1;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 64'h0;
    end
    if (rst_n && req_ready && mem_req_valid) r1_viol++;
  end

  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      exp_t g;
      checks++;
      g = '{done_fault, done_level, done_paddr, done_size, done_write, done_user, done_nx,
            4'(req_cnt - rd_base)};
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R11 unexpected result got=%h expected none", g);
      end else begin
        exp_t e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (g !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, g, e);
        end
      end
    end
  end

  function automatic exp_t mk(input logic f, input logic [2:0] l, input logic [51:0] pa,
                              input logic [1:0] sz, input logic wr, input logic us,
                              input logic xd, input logic [3:0] rd);
    mk = '{f, l, pa, sz, wr, us, xd, rd};
  endfunction

  task automatic put(input logic [63:0] tb, input logic [8:0] idx, input logic [63:0] v);
    mem[{tb[51:12], idx, 3'b000}] = v;
  endtask

  task automatic build(input logic [63:0] va, input logic [63:0] f4, input logic [63:0] f3,
                       input logic [63:0] f2, input logic [63:0] f1, input int n,
                       output logic [63:0] root);
    logic [63:0] t [4];
    for (int i = 0; i < 4; i++) begin
      t[i] = next_tbl;
      next_tbl = next_tbl + 64'h1000;
    end
    root = t[0];
    put(t[0], va[47:39], n > 1 ? (f4 | t[1]) : f4);
    if (n > 1) put(t[1], va[38:30], n > 2 ? (f3 | t[2]) : f3);
    if (n > 2) put(t[2], va[29:21], n > 3 ? (f2 | t[3]) : f2);
    if (n > 3) put(t[3], va[20:12], f1);
  endtask

  task automatic go(input logic [63:0] va, input logic [63:0] root, input exp_t e, input string tag);
    while (!req_ready) @(negedge clk);
    rd_base = req_cnt;
    expq.push_back(e);
    tagq.push_back(tag);
    req_valid = 1'b1;
    req_vaddr = va;
    root_base = root;
    @(negedge clk);
    req_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string msg, input logic [63:0] act, input logic [63:0] ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", msg, act, ex);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] root, va, lf;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready in reset", {63'h0, req_ready}, 64'h1);
    chk(done_valid == 1'b0, "R11 no result in reset", {63'h0, done_valid}, 64'h0);
    chk(mem_req_valid == 1'b0, "R4 no read in reset", {63'h0, mem_req_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 R3: plain 4 KiB walk, full permissions
    va = 64'h0000_7F12_3456_7ABC;
    lf = 64'h0000_000A_BCDE_F000 | PWU;
    build(va, PWU, PWU, PWU, lf, 4, root);
    go(va, root, mk(0, 0, {lf[51:12], va[11:0]}, 0, 1, 1, 0, 4), "R9 R3 4K walk");

    // R10 R4: mixed permissions with memory back-pressure
    stall = 1'b1;
    va = 64'h0000_0123_4567_89AB;
    lf = 64'h0000_0003_3333_3000 | PWU;
    build(va, PWU, P | U, PWU | XD, lf, 4, root);
    go(va, root, mk(0, 0, {lf[51:12], va[11:0]}, 0, 0, 1, 1, 4), "R10 R4 perms under stall");
    stall = 1'b0;

    // R10: user cleared at leaf only
    va = 64'h0000_4444_5555_6666;
    lf = 64'h0000_0007_7777_7000 | P | W;
    build(va, PWU, PWU, PWU, lf, 4, root);
    go(va, root, mk(0, 0, {lf[51:12], va[11:0]}, 0, 1, 0, 0, 4), "R10 user and");

    // R7: 1 GiB page
    va = 64'h0000_2AAA_FFFF_1234;
    lf = 64'h0000_0FC0_0000_0000 | PWU | PS;
    build(va, PWU, lf, 0, 0, 2, root);
    go(va, root, mk(0, 0, {lf[51:30], va[29:0]}, 2, 1, 1, 0, 2), "R7 1G page");

    // R8: 2 MiB page, execute-disable at top
    va = 64'h0000_1357_9BDF_FFFF;
    lf = 64'h0000_0012_3460_0000 | PWU | PS;
    build(va, PWU | XD, PWU, lf, 0, 3, root);
    go(va, root, mk(0, 0, {lf[51:21], va[20:0]}, 1, 1, 1, 1, 3), "R8 2M page");

    // R2: canonical upper-half address walks normally
    va = 64'hFFFF_8000_1234_5678;
    lf = 64'h0000_0000_0055_5000 | PWU;
    build(va, PWU, PWU, PWU, lf, 4, root);
    go(va, root, mk(0, 0, {lf[51:12], va[11:0]}, 0, 1, 1, 0, 4), "R2 upper canonical");

    // R2: non-canonical and bad root fault without reads
    go(64'h0001_0000_0000_0000, root, mk(1, 0, 0, 0, 0, 0, 0, 0), "R2 non-canonical");
    go(64'hFFFF_0000_0000_0000, root, mk(1, 0, 0, 0, 0, 0, 0, 0), "R2 non-canonical high");
    go(64'h0000_0000_0000_1000, 64'h0010_0000_0001_0000, mk(1, 0, 0, 0, 0, 0, 0, 0), "R2 root reserved");

    // R5: not present at top and at page table
    va = 64'h0000_0600_0000_0000;
    build(va, 64'h0, 0, 0, 0, 1, root);
    go(va, root, mk(1, 4, 0, 0, 0, 0, 0, 1), "R5 top absent");
    va = 64'h0000_0700_0040_3000;
    build(va, PWU, PWU, PWU, 64'h0000_0000_1234_5006, 4, root);
    go(va, root, mk(1, 1, 0, 0, 0, 0, 0, 4), "R5 leaf absent");

    // R6: reserved bits at each checked level
    va = 64'h0000_0800_0000_0000;
    build(va, PWU | PS, 0, 0, 0, 1, root);
    go(va, root, mk(1, 4, 0, 0, 0, 0, 0, 1), "R6 top size bit");
    va = 64'h0000_0900_4000_0000;
    build(va, PWU, 64'h0000_0040_0000_2000 | PWU | PS, 0, 0, 2, root);
    go(va, root, mk(1, 3, 0, 0, 0, 0, 0, 2), "R6 1G reserved");
    va = 64'h0000_0A00_0020_0000;
    build(va, PWU, PWU, 64'h0000_0000_0010_0000 | PWU | PS, 0, 3, root);
    go(va, root, mk(1, 2, 0, 0, 0, 0, 0, 3), "R6 2M reserved");

    // R1: second request held during a busy walk is ignored
    va = 64'h0000_0B0C_0D0E_0F00;
    lf = 64'h0000_0009_9999_9000 | PWU;
    build(va, PWU, PWU, PWU, lf, 4, root);
    while (!req_ready) @(negedge clk);
    rd_base = req_cnt;
    expq.push_back(mk(0, 0, {lf[51:12], va[11:0]}, 0, 1, 1, 0, 4));
    tagq.push_back("R1 busy ignore");
    req_valid = 1'b1;
    req_vaddr = va;
    root_base = root;
    @(negedge clk);
    req_vaddr = 64'h0001_0000_0000_0000;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    while (expq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);

    chk(r1_viol == 0, "R1 ready high during read", 64'(r1_viol), 64'h0);
    chk(r4_viol == 0, "R4 request dropped or changed", 64'(r4_viol), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule